// File: doc/BRIEF.md
# Idle-Slot and Deadline Refresh Scheduler

This block decides, cycle by cycle, whether a paged dynamic memory array serves the processor or refreshes one of its rows. The array holds `PAGES` pages of `WORDS` rows each. Every cycle the processor raises `memReq` if it needs the array. When the array is idle, the scheduler uses the cycle to refresh the next row. This costs the processor nothing. A refresh cycle never touches the data bus, so the processor bus interface is enabled only through `grant`. Refresh cycles and granted cycles never coincide.

The scheduler also counts the cycles since the last refresh of any kind. Suppose a busy processor has kept every cycle occupied until the distance reaches `MAX_GAP` cycles. The scheduler then takes that cycle for a forced refresh and raises `stall` for exactly that one cycle. The request that was refused is remembered and granted in the following cycle, even if `memReq` has already dropped by then. Rows are visited in one fixed sweep. The row index within the page advances fastest. The page advances when the row index wraps. Because the spacing between refreshes is bounded, any row is revisited within `PAGES*WORDS*MAX_GAP` cycles. The integrator chooses `MAX_GAP` so that this sweep fits inside the retention budget. For 384 rows at 100 MHz and a budget under 1 ms, the default of 256 gives a sweep of 983 µs.

Top module: `refresh_scheduler`

## Requirements
- R1: While `rstN` is low, `refresh`, `stall` and `grant` are 0. The first refresh after reset targets page 0, row 0.
- R2: A cycle with `memReq` low and no held request is a refresh cycle with `grant` 0 and `stall` 0.
- R3: `refresh` and `grant` are never 1 in the same cycle, so the data bus stays disabled during refresh.
- R4: Each refresh, forced or opportunistic, advances the address. `refWord` counts 0..WORDS-1. When `refWord` wraps to 0, `refPage` counts 0..PAGES-1 and then wraps to 0.
- R5: Consecutive refresh cycles, with reset counting as a refresh one cycle before the first active cycle, are never more than `MAX_GAP` cycles apart. A requested cycle that lies exactly `MAX_GAP` cycles after the previous refresh becomes a forced refresh.
- R6: `stall` is never 1 in two consecutive cycles.
- R7: In the cycle after a stall, `grant` is 1 whatever the value of `memReq`.
- R8: `stall` is 1 only in a refresh cycle. Every requested cycle that is not stalled is granted.
- R9: A requested cycle less than `MAX_GAP` cycles after the previous refresh is granted without a refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memReq | input | 1 | Processor needs the array this cycle |
| grant | output | 1 | Processor access taken this cycle; enables the data bus |
| stall | output | 1 | Processor halted this cycle for a forced refresh |
| refresh | output | 1 | This cycle refreshes the addressed row |
| refPage | output | $clog2(PAGES) | Page of the row being refreshed |
| refWord | output | $clog2(WORDS) | Row within the page being refreshed |

## Verification
The bench sweeps bursts of requests of every length from 1 to beyond `MAX_GAP`, so the deadline is met at each possible phase of the age counter. An off-by-one in the age comparison shows up as a forced refresh one cycle early or late. A scheduler that drops the refused request appears in the cycles where `memReq` falls right after a stall: it would refresh instead of granting. Long idle runs cross the word wrap and the page wrap (three pages, a count that is not a power of two), which exposes a wrong wrap value or a page that fails to advance. Back-to-back stalls and refresh cycles that also grant are checked on every cycle.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // Per-cycle decision passed from control to datapath
  typedef struct packed {
    logic doRefresh;  // cycle belongs to refresh
    logic doStall;    // processor halted this cycle
    logic doGrant;    // processor access taken this cycle
  } schedStrobe_t;

endpackage

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
#(
  parameter int MAX_GAP = 256
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         memReq,
  output schedStrobe_t strobe
);

  localparam int AGE_W = (MAX_GAP > 2) ? $clog2(MAX_GAP) : 1;
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(MAX_GAP - 1);

  logic [AGE_W-1:0] ageQ;
  logic             heldQ;
  logic             reqEff;
  logic             deadline;
  logic             forceRef;

  // A held request counts as a request in the cycle after a stall
  always_comb begin
    reqEff   = memReq | heldQ;
    deadline = (ageQ == AGE_LAST);
    forceRef = reqEff & deadline;
    strobe.doRefresh = rstN & (~reqEff | forceRef);
    strobe.doStall   = rstN & forceRef;
    strobe.doGrant   = rstN & reqEff & ~forceRef;
  end

  // Age saturates at AGE_LAST by construction: that cycle always refreshes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageQ  <= '0;
      heldQ <= 1'b0;
    end else begin
      heldQ <= strobe.doStall;
      if (strobe.doRefresh) ageQ <= '0;
      else                  ageQ <= ageQ + 1'b1;
    end
  end

endmodule

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int PAGES = 12,
  parameter int WORDS = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  schedStrobe_t              strobe,
  output logic                      refresh,
  output logic                      stall,
  output logic                      grant,
  output logic [$clog2(PAGES)-1:0]  refPage,
  output logic [$clog2(WORDS)-1:0]  refWord
);

  localparam int PAGE_W = $clog2(PAGES);
  localparam int WORD_W = $clog2(WORDS);
  localparam bit PAGE_POW2 = (PAGES == (1 << PAGE_W));
  localparam bit WORD_POW2 = (WORDS == (1 << WORD_W));
  localparam logic [PAGE_W-1:0] PAGE_LAST = PAGE_W'(PAGES - 1);
  localparam logic [WORD_W-1:0] WORD_LAST = WORD_W'(WORDS - 1);

  logic [PAGE_W-1:0] pageQ, pageNext;
  logic [WORD_W-1:0] wordQ, wordNext;
  logic              wordWrap;

  assign wordWrap = (wordQ == WORD_LAST);

  // Power-of-two sizes wrap naturally; others compare against the last index
  generate
    if (WORD_POW2) begin : g_wordNat
      assign wordNext = wordQ + 1'b1;
    end else begin : g_wordCmp
      assign wordNext = wordWrap ? '0 : wordQ + 1'b1;
    end
    if (PAGE_POW2) begin : g_pageNat
      assign pageNext = pageQ + 1'b1;
    end else begin : g_pageCmp
      assign pageNext = (pageQ == PAGE_LAST) ? '0 : pageQ + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0;
      wordQ <= '0;
    end else if (strobe.doRefresh) begin
      wordQ <= wordNext;
      if (wordWrap) pageQ <= pageNext;
    end
  end

  assign refresh = strobe.doRefresh;
  assign stall   = strobe.doStall;
  assign grant   = strobe.doGrant;
  assign refPage = pageQ;
  assign refWord = wordQ;

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int PAGES   = 12,
  parameter int WORDS   = 32,
  parameter int MAX_GAP = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     memReq,
  output logic                     grant,
  output logic                     stall,
  output logic                     refresh,
  output logic [$clog2(PAGES)-1:0] refPage,
  output logic [$clog2(WORDS)-1:0] refWord
);

  schedStrobe_t strobe;

  refsched_ctrl #(.MAX_GAP(MAX_GAP)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .memReq (memReq),
    .strobe (strobe)
  );

  refsched_dp #(.PAGES(PAGES), .WORDS(WORDS)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .refresh (refresh),
    .stall   (stall),
    .grant   (grant),
    .refPage (refPage),
    .refWord (refWord)
  );

endmodule

// File: rtl/refsched_checker.sv
module refsched_checker #(
  parameter int MAX_GAP = 256,
  parameter int PAGE_W  = 4,
  parameter int WORD_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              grant,
  input logic              stall,
  input logic              refresh,
  input logic [PAGE_W-1:0] refPage,
  input logic [WORD_W-1:0] refWord
);

  localparam int GAP_W = $clog2(MAX_GAP + 1);

  // Cycles since the last refresh, kept independently of the design
  logic [GAP_W-1:0] gapQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        gapQ <= '0;
    else if (refresh) gapQ <= '0;
    else              gapQ <= gapQ + 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (!refresh && !stall && !grant));

  p_idle_refresh_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && !$past(stall)) |-> (refresh && !grant));

  p_bus_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(refresh && grant));

  p_row_moves_r4: assert property (@(posedge clk) disable iff (!rstN)
    refresh |=> !($stable(refPage) && $stable(refWord)));

  p_row_still_r4: assert property (@(posedge clk) disable iff (!rstN)
    !refresh |=> ($stable(refPage) && $stable(refWord)));

  p_deadline_r5: assert property (@(posedge clk) disable iff (!rstN)
    (gapQ == GAP_W'(MAX_GAP - 1)) |-> refresh);

  p_single_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  p_held_grant_r7: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> grant);

  p_stall_refresh_r8: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> refresh);

  p_one_role_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !stall) |-> grant);

endmodule

bind refresh_scheduler refsched_checker #(
  .MAX_GAP (MAX_GAP),
  .PAGE_W  ($clog2(PAGES)),
  .WORD_W  ($clog2(WORDS))
) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .memReq  (memReq),
  .grant   (grant),
  .stall   (stall),
  .refresh (refresh),
  .refPage (refPage),
  .refWord (refWord)
);

// File: tb/test_refresh_scheduler.sv
module test_refresh_scheduler;

  localparam int PAGES   = 3;
  localparam int WORDS   = 4;
  localparam int MAX_GAP = 5;
  localparam int ROWS    = PAGES * WORDS;
  localparam int PW      = $clog2(PAGES);
  localparam int WW      = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          memReq = 1'b1;
  logic          grant, stall, refresh;
  logic [PW-1:0] refPage;
  logic [WW-1:0] refWord;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state, derived from the requirements
  int  mAge = 0;
  bit  mHeld = 0;
  int  mPage = 0;
  int  mWord = 0;
  int  cyc = 0;
  int  lastRef = -1;
  bit  lastStall = 0;
  logic [7:0] lfsr = 8'hA5;

  always #4 clk = ~clk;  // 125 MHz

  refresh_scheduler #(.PAGES(PAGES), .WORDS(WORDS), .MAX_GAP(MAX_GAP)) i_refresh_scheduler (
    .clk(clk), .rstN(rstN), .memReq(memReq), .grant(grant), .stall(stall),
    .refresh(refresh), .refPage(refPage), .refWord(refWord)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Drive one cycle at the falling edge, check before the rising edge
  task automatic runCycle(input bit req);
    bit reqEff, expForce, expRef;
    memReq = req;
    #2;
    reqEff   = req | mHeld;
    expForce = reqEff && (mAge == MAX_GAP - 1);
    expRef   = !reqEff || expForce;
    chk(expForce ? "R5" : (!reqEff ? "R2" : "R9"), int'(refresh), int'(expRef));
    chk(expForce ? "R8" : "R6", int'(stall), int'(expForce));
    chk(mHeld ? "R7" : "R8", int'(grant), int'(reqEff && !expForce));
    chk("R3", int'(refresh && grant), 0);
    if (stall) chk("R6", int'(lastStall), 0);
    if (refresh) begin
      chk("R4", int'(refPage), mPage);
      chk("R4", int'(refWord), mWord);
      chk("R5", int'((cyc - lastRef) <= MAX_GAP), 1);
      lastRef = cyc;
    end
    mHeld = expForce;
    mAge  = expRef ? 0 : mAge + 1;
    if (expRef) begin
      mWord = mWord + 1;
      if (mWord == WORDS) begin
        mWord = 0;
        mPage = (mPage + 1) % PAGES;
      end
    end
    lastStall = stall;
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1", int'(refresh), 0);
    chk("R1", int'(stall), 0);
    chk("R1", int'(grant), 0);
    @(negedge clk);
    rstN = 1'b1;
    // long idle run: crosses word and page wraps twice
    for (int i = 0; i < 2 * ROWS + 1; i++) runCycle(1'b0);
    // continuous requests: a forced refresh every MAX_GAP cycles
    for (int i = 0; i < 4 * MAX_GAP; i++) runCycle(1'b1);
    // request dropped right after each stall: held request must win
    for (int i = 0; i < 6 * MAX_GAP; i++) runCycle(!lastStall);
    // alternating pattern
    for (int i = 0; i < 40; i++) runCycle(i[0]);
    // bursts of every length around the limit, one idle cycle between
    for (int len = 1; len <= MAX_GAP + 2; len++) begin
      for (int rep = 0; rep < 3; rep++) begin
        for (int k = 0; k < len; k++) runCycle(1'b1);
        runCycle(1'b0);
      end
    end
    // pseudo-random, mostly busy
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      runCycle(lfsr[1:0] != 2'b00);
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R5: watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule